// File: doc/BRIEF.md
# Serial Clock and Parameter Memory

This block is a small timekeeping and settings store that a host reaches over a three-wire serial link. The link has a frame select (active low), a serial clock and a data line. The data line is split here into a host-to-block input and a block-to-host output. Inside sits a 32-byte memory. Its three lowest bytes form a seconds count that steps once for every pulse on a one-second tick input.

The host lowers the frame select and clocks in a 16-bit command, most significant bit first. The top bit picks the direction. The next five bits pick a byte of the memory. The low eight bits carry the data when writing. On a read, the block takes over the data output halfway through the frame and presents the addressed byte. The serial clock is sampled against the system clock. A bit moves on the first system-clock edge at which the serial clock is seen low after having been seen high.

Top module: `serial_pram`

## Requirements
- R1: After a synchronous active-low reset, `sdo` is 0 and every memory byte reads back as 0x00.
- R2: While `cs_n` is high, the bit position and the command register are cleared and `sdo` is 0. A frame cut short by raising `cs_n` leaves no trace on the next frame.
- R3: Serial bits move only on a falling edge of `sck`, seen as high in the previous system clock and low in this one. The level of `sdi` at any other time has no effect.
- R4: A frame is 16 bits, most significant bit first. Bit 15 = 1 selects a read and bit 15 = 0 selects a write. Bits 14..10 are the byte address, and bits 9..8 are don't-care.
- R5: On a read, the 9th falling edge loads the addressed byte and drives its bit 7 on `sdo`. The 10th to 16th edges drive bits 6 down to 0. Each bit appears one system clock after the edge is seen and holds until the next edge.
- R6: On a write, bits 7..0 of the frame are stored at the addressed byte on the 16th falling edge. A frame aborted before that edge writes nothing.
- R7: Each `sec_tick` pulse adds one to bytes 0..2 taken as a 24-bit little-endian count. A byte steps only when every byte below it was 0xFF.
- R8: A tick leaves bytes 3..31 unchanged.
- R9: After the 16th falling edge the bit position holds. Further edges until `cs_n` rises cause no write and keep `sdo` at 0.
- R10: `sdo` is 0 whenever no read data bit is being presented: during the command half of any frame, during all of a write frame, and outside frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select; high clears the frame, low allows transfers |
| sck | input | 1 | Serial clock from the host, sampled on `clk` |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host, 0 when idle |
| sec_tick | input | 1 | One-cycle pulse each second |

## Verification
A read data bit is due on `sdo` one system clock after the clock edge at which `sck` is first sampled low. The bench drives `sck` low on a falling `clk` edge and records each expected bit with that due cycle. The monitor compares the bit on the falling `clk` edge of the due cycle, away from the edge where it changes. Writes and ticks show up in the next read frame, so each is checked through `sdo` and never through internal state.

// File: rtl/serial_pram_pkg.sv
// Shared types for the serial parameter memory.
// Assumes: nothing beyond IEEE 1800-2017.
package serial_pram_pkg;

    // Phase of the current frame, derived from bit position and direction.
    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,   // shifting in the command half
        PH_WDATA = 2'd1,   // shifting in write data
        PH_RDATA = 2'd2,   // presenting read data
        PH_DONE  = 2'd3    // frame complete, position saturated
    } frame_phase_e;

endpackage

// File: rtl/serial_pram_edge.sv
// Falling-edge detector for the serial clock.
// It compares the current sck level with the level seen one clk earlier.
// Assumes sck is already synchronous to clk; no metastability filter.
module serial_pram_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic fall
);

    logic sck_q;

    // Remember the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign fall = sck_q & ~sck;

endmodule

// File: rtl/serial_pram_frame.sv
// Frame sequencer: bit position, command capture, read shifter and sdo.
// It issues a one-cycle write strobe on the final bit of a write frame.
// Assumes fall is a one-cycle pulse per serial clock falling edge.
module serial_pram_frame
    import serial_pram_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo
);

    localparam int HDR_W = CMD_W - DATA_W;
    localparam int POS_W = $clog2(CMD_W + 1);

    logic [POS_W-1:0]  pos;
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] rd_shift;
    logic [CMD_W-1:0]  bit_mask;
    frame_phase_e      phase;

    // Decode the frame phase from position and direction bit.
    always_comb begin
        if (pos == POS_W'(CMD_W))      phase = PH_DONE;
        else if (pos < POS_W'(HDR_W))  phase = PH_CMD;
        else if (cmd[CMD_W-1])         phase = PH_RDATA;
        else                           phase = PH_WDATA;
    end

    // One-hot mask for the command bit at the current position, MSB first.
    assign bit_mask = {1'b1, {(CMD_W-1){1'b0}}} >> pos;

    assign addr    = cmd[CMD_W-2 -: ADDR_W];
    assign wr_data = {cmd[DATA_W-1:1], sdi};
    assign wr_en   = !cs_n && fall && (phase == PH_WDATA)
                     && (pos == POS_W'(CMD_W-1));

    // Advance the frame on each serial falling edge; clear while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            pos      <= '0;
            cmd      <= '0;
            rd_shift <= '0;
            sdo      <= 1'b0;
        end else if (fall) begin
            case (phase)
                PH_CMD, PH_WDATA: begin
                    if (sdi) cmd <= cmd | bit_mask;
                    sdo <= 1'b0;
                    pos <= pos + POS_W'(1);
                end
                PH_RDATA: begin
                    if (pos == POS_W'(HDR_W)) begin
                        sdo      <= rd_byte[DATA_W-1];
                        rd_shift <= rd_byte << 1;
                    end else begin
                        sdo      <= rd_shift[DATA_W-1];
                        rd_shift <= rd_shift << 1;
                    end
                    pos <= pos + POS_W'(1);
                end
                default: sdo <= 1'b0;
            endcase
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (pos == '0) && !sdo); // R2
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !fall) |=> $stable(pos)); // R3
    AST_WRITE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pos == POS_W'(CMD_W))); // R6
    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_W'(CMD_W)); // R9
    AST_SDO_CMD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && fall && (pos < POS_W'(HDR_W))) |=> !sdo); // R10

endmodule

// File: rtl/serial_pram_store.sv
// Byte memory with a little-endian seconds count in its lowest bytes.
// A serial write to a byte takes precedence over a tick for that byte.
// Assumes DEPTH exceeds CNT_BYTES and tick is a one-cycle pulse.
module serial_pram_store #(
    parameter int DEPTH     = 32,
    parameter int DATA_W    = 8,
    parameter int CNT_BYTES = 3,
    parameter int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;
    logic [CNT_BYTES:0]           carry;

    // Carry chain: byte g steps when every lower count byte is all ones.
    assign carry[0] = 1'b1;
    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_carry
        assign carry[g+1] = carry[g] && (mem[g] == {DATA_W{1'b1}});
    end

    // Apply serial writes and tick increments to the byte array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && (wr_addr == ADDR_W'(i)))
                    mem[i] <= wr_data;
                else if (tick && (i < CNT_BYTES) && carry[i])
                    mem[i] <= mem[i] + DATA_W'(1);
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_TICK_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && wr_addr == '0)) |=>
        (mem[0] == DATA_W'($past(mem[0]) + DATA_W'(1)))); // R7
    AST_TICK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> $stable(mem[CNT_BYTES])); // R8

endmodule

// File: rtl/serial_pram.sv
// Top level: serial link into a byte memory with a seconds count.
// It wires edge detection, the frame sequencer and the store together.
// Assumes sck, sdi, cs_n and sec_tick are synchronous to clk.
module serial_pram #(
    parameter int DEPTH     = 32,
    parameter int DATA_W    = 8,
    parameter int CMD_W     = 16,
    parameter int CNT_BYTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sdo,
    input  logic sec_tick
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic              fall;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_byte;

    serial_pram_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .fall  (fall)
    );

    serial_pram_frame #(
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .fall    (fall),
        .sdi     (sdi),
        .rd_byte (rd_byte),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sdo     (sdo)
    );

    serial_pram_store #(
        .DEPTH     (DEPTH),
        .DATA_W    (DATA_W),
        .CNT_BYTES (CNT_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_byte)
    );

endmodule

// File: tb/serial_pram_test.sv
module serial_pram_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sec_tick = 1'b0;
    logic sdo;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    typedef struct {
        logic  v;
        int    due;
        string tag;
    } exp_t;
    exp_t q[$];

    serial_pram uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .sdi      (sdi),
        .sdo      (sdo),
        .sec_tick (sec_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expected sdo bits on the falling clk edge of their due cycle.
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            checks++;
            if (e.due != cyc || sdo !== e.v) begin
                fails++;
                $display("FAIL %s: sdo=%b expected %b (due %0d, cycle %0d)",
                         e.tag, sdo, e.v, e.due, cyc);
            end
        end
    end

    // Driver: one serial bit; optional expected sdo after the falling edge.
    task automatic sbit(input logic b, input logic chk, input logic e,
                        input string tag, input logic glitch);
        @(negedge clk); sdi = glitch ? ~b : b; sck = 1'b1;
        @(negedge clk); if (glitch) sdi = b;
        @(negedge clk); sck = 1'b0;
        if (chk) q.push_back('{e, cyc + 1, tag});
        @(negedge clk); if (glitch) sdi = ~b;
        @(negedge clk);
    endtask

    task automatic frame_wr(input logic [4:0] a, input logic [7:0] d,
                            input logic glitch, input int extra, input string tag);
        logic [15:0] w;
        w = {1'b0, a, 2'b00, d};
        @(negedge clk); cs_n = 1'b0;
        for (int i = 15; i >= 0; i--) sbit(w[i], 1'b1, 1'b0, {tag, " R10 write"}, glitch);
        for (int i = 0; i < extra; i++) sbit(1'b1, 1'b1, 1'b0, "R9 extra edge", 1'b0);
        @(negedge clk); cs_n = 1'b1;
        q.push_back('{1'b0, cyc + 1, "R2 idle"});
        @(negedge clk);
    endtask

    task automatic frame_rd(input logic [4:0] a, input logic [7:0] d,
                            input int extra, input string tag);
        logic [15:0] w;
        w = {1'b1, a, 2'b00, 8'h00};
        @(negedge clk); cs_n = 1'b0;
        for (int i = 15; i >= 8; i--) sbit(w[i], 1'b1, 1'b0, "R10 command half", 1'b0);
        for (int i = 7; i >= 0; i--) sbit(1'b0, 1'b1, d[i], {tag, " R5 read bit"}, 1'b0);
        for (int i = 0; i < extra; i++) sbit(1'b0, 1'b1, 1'b0, "R9 extra edge", 1'b0);
        @(negedge clk); cs_n = 1'b1;
        q.push_back('{1'b0, cyc + 1, "R10 idle"});
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (sdo !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset sdo: actual %b expected 0", sdo);
        end

        // R1: memory clear after reset
        frame_rd(5'd0,  8'h00, 0, "R1");
        frame_rd(5'd5,  8'h00, 0, "R1");
        frame_rd(5'd31, 8'h00, 0, "R1");

        // R4/R6: writes to several addresses, MSB-first read back
        frame_wr(5'd5,  8'hA5, 1'b0, 0, "R6");
        frame_wr(5'd31, 8'h3C, 1'b0, 0, "R4");
        frame_wr(5'd3,  8'h77, 1'b0, 0, "R4");
        frame_rd(5'd5,  8'hA5, 0, "R6");
        frame_rd(5'd31, 8'h3C, 0, "R4");

        // R2/R6: aborted write frame to byte 5 leaves it unchanged
        @(negedge clk); cs_n = 1'b0;
        for (int i = 15; i >= 4; i--)
            sbit(({1'b0, 5'd5, 2'b00, 8'h00} >> i) & 16'h1, 1'b1, 1'b0, "R10 abort", 1'b0);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        frame_rd(5'd5, 8'hA5, 0, "R2 abort");

        // R3: sdi toggles while sck is high and after the edge
        frame_wr(5'd7, 8'hC3, 1'b1, 0, "R3");
        frame_rd(5'd7, 8'hC3, 0, "R3");

        // R7/R8: tick count with carry across bytes
        frame_wr(5'd0, 8'hFE, 1'b0, 0, "R7");
        frame_wr(5'd1, 8'hFF, 1'b0, 0, "R7");
        frame_wr(5'd2, 8'h12, 1'b0, 0, "R7");
        pulse_tick();
        frame_rd(5'd0, 8'hFF, 0, "R7 first tick");
        frame_rd(5'd1, 8'hFF, 0, "R7 first tick");
        pulse_tick();
        frame_rd(5'd0, 8'h00, 0, "R7 carry");
        frame_rd(5'd1, 8'h00, 0, "R7 carry");
        frame_rd(5'd2, 8'h13, 0, "R7 carry");
        frame_rd(5'd3, 8'h77, 0, "R8");
        frame_rd(5'd31, 8'h3C, 0, "R8");

        // R9: extra edges after a complete frame
        frame_wr(5'd9, 8'h5A, 1'b0, 4, "R9");
        frame_rd(5'd9, 8'h5A, 3, "R9");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule